// File: doc/BRIEF.md
# Alarm and periodic interrupt unit

This block merges three interrupt sources of a real-time clock onto one active-low line that can share a wired-OR net with other devices. The first source is a time-of-day alarm. It compares the current BCD seconds, minutes and hours with three programmed values, and it does so only on the seconds tick. The second source is a periodic rate. A 4-bit code selects one of fifteen rates, from 128 Hz down to once per day. The third source is a power-fail input. This input is asynchronous, so it passes through a flip-flop synchronizer and raises a flag once on each rising edge. Each source has its own enable and its own status bit.

The line is modelled as an open-drain pin: `irq_oe` high means the pin is pulled low, and `irq_n` is the value seen on the pin with no other driver. A small state machine owns the line. It has two states. `IRQ_IDLE` releases the line. `IRQ_ASSERT` drives it low. The transition *raise* (IDLE to ASSERT) happens on any set event. The transition *ack* (ASSERT to IDLE) happens on a status read that coincides with no new set event. In every other case the machine stays in its current state (*hold*). Software reads `status` and pulses `stat_rd`, which clears every bit that was set.

Top module: `rtc_irq_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `status` is 0, `irq_oe` is 0 and `irq_n` is 1.
- R2: Status bit 0 (alarm) sets at the clock edge where `tick_sec` is high, `alarm_en` is high, and `now_sec`, `now_min`, `now_hr` equal `alm_sec`, `alm_min`, `alm_hr`.
- R3: The alarm bit does not set in three cases: without `tick_sec` even if the time still matches, when any one field differs, or when `alarm_en` is low.
- R4: Status bit 1 (periodic) covers rate codes 1 to 7 (128, 64, 32, 16, 8, 4, 2 Hz). With code k, the bit sets on the base ticks (`tick_base`) whose count since reset is a multiple of 2^(k-1).
- R5: Status bit 1 also covers the slower codes. The "new value" named for each code is the value `now_sec`/`now_min` shows in the tick cycle.
  - Code 8 sets it on every `tick_sec`.
  - Code 9 sets it on `tick_sec` with a new seconds low digit of 0.
  - Code 10 sets it on `tick_sec` with new seconds 00 or 30.
  - Code 11 sets it on `tick_min`.
  - Code 12 sets it on `tick_min` with a new minutes low digit of 0.
  - Code 13 sets it on `tick_min` with new minutes 00 or 30.
  - Code 14 sets it on `tick_hr`.
  - Code 15 sets it on `tick_day`.
- R6: Rate code 0 never sets the periodic bit, whatever ticks arrive.
- R7: Status bit 2 (power fail) sets within three clock edges of a rising edge on `pfail_raw` when `pfail_en` is high. It sets only once per rising edge, and it does not set when `pfail_en` is low.
- R8: `irq_oe` is high and `irq_n` is low exactly while at least one status bit is set. Otherwise the line is released.
- R9: A cycle with `stat_rd` high clears all status bits at that edge, except that a set event in the same cycle leaves its own bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_base | input | 1 | 128 Hz base pulse, one cycle wide |
| tick_sec | input | 1 | Seconds rollover pulse |
| tick_min | input | 1 | Minutes rollover pulse |
| tick_hr | input | 1 | Hours rollover pulse |
| tick_day | input | 1 | Day rollover pulse |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hr | input | 8 | Current hours, BCD |
| alm_sec | input | 8 | Alarm seconds, BCD |
| alm_min | input | 8 | Alarm minutes, BCD |
| alm_hr | input | 8 | Alarm hours, BCD |
| alarm_en | input | 1 | Alarm source enable |
| pfail_en | input | 1 | Power-fail source enable |
| rate_code | input | 4 | Periodic rate select, 0 = off |
| pfail_raw | input | 1 | Asynchronous power-fail indication |
| stat_rd | input | 1 | Status read strobe, clears flags |
| status | output | 3 | Flags: bit0 alarm, bit1 periodic, bit2 power fail |
| irq_oe | output | 1 | High when the pin is pulled low |
| irq_n | output | 1 | Modelled pin value, active low |

## Verification
A wrong line state shows at the pin on the very edge after the mismatch. A machine stuck in `IRQ_ASSERT` keeps `irq_n` low one cycle after a read that returned the flags to zero, and one stuck in `IRQ_IDLE` leaves the pin high beside a nonzero status. A prescaler that drifts out of phase moves sub-second flags off their power-of-two base-tick counts, so the error is visible on the first tick that should or should not fire. An alarm that is not gated by the tick shows up as a flag returning one cycle after a read while the time still matches. A broken synchronizer edge detector either misses the power-fail flag within three edges or sets it again after a read.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int BCD_W    = 8;
    localparam int CODE_W   = 4;
    localparam int NUM_SRC  = 3;
    localparam int SRC_ALM  = 0;
    localparam int SRC_PER  = 1;
    localparam int SRC_PF   = 2;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_ASSERT = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irq_alarm_cmp.sv
module irq_alarm_cmp
    import irq_pkg::*;
#(
    parameter int FIELDS = 3
) (
    input  logic             tick_sec,
    input  logic             enable,
    input  logic [BCD_W-1:0] now_f [FIELDS],
    input  logic [BCD_W-1:0] alm_f [FIELDS],
    output logic             hit
);
    logic [FIELDS-1:0] eq;

    for (genvar i = 0; i < FIELDS; i++) begin : g_field
        assign eq[i] = (now_f[i] == alm_f[i]);
    end

    // compare only on the seconds tick: one flag per matching second
    assign hit = enable & tick_sec & (&eq);
endmodule

// File: rtl/irq_rate_sel.sv
module irq_rate_sel
    import irq_pkg::*;
#(
    parameter int SUB_RATES = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_base,
    input  logic              tick_sec,
    input  logic              tick_min,
    input  logic              tick_hr,
    input  logic              tick_day,
    input  logic [BCD_W-1:0]  now_sec,
    input  logic [BCD_W-1:0]  now_min,
    input  logic [CODE_W-1:0] rate_code,
    output logic              hit
);
    localparam int DIV_W = SUB_RATES - 1;
    localparam logic [CODE_W-1:0] C_SUB_MAX = CODE_W'(SUB_RATES);
    localparam logic [CODE_W-1:0] C_1S      = CODE_W'(SUB_RATES + 1);
    localparam logic [CODE_W-1:0] C_10S     = CODE_W'(SUB_RATES + 2);
    localparam logic [CODE_W-1:0] C_30S     = CODE_W'(SUB_RATES + 3);
    localparam logic [CODE_W-1:0] C_1M      = CODE_W'(SUB_RATES + 4);
    localparam logic [CODE_W-1:0] C_10M     = CODE_W'(SUB_RATES + 5);
    localparam logic [CODE_W-1:0] C_30M     = CODE_W'(SUB_RATES + 6);
    localparam logic [CODE_W-1:0] C_1H      = CODE_W'(SUB_RATES + 7);
    localparam logic [CODE_W-1:0] C_1D      = CODE_W'(SUB_RATES + 8);

    logic [DIV_W-1:0]     pre_q;
    logic [SUB_RATES:1]   sub_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pre_q <= '0;
        else if (tick_base) pre_q <= pre_q + 1'b1;
    end

    for (genvar k = 1; k <= SUB_RATES; k++) begin : g_sub
        if (k == 1) begin : g_full
            assign sub_hit[k] = tick_base;
        end else begin : g_div
            assign sub_hit[k] = tick_base & (&pre_q[k-2:0]);
        end
    end

    logic sec_d0, sec_half, min_d0, min_half;
    assign sec_d0   = (now_sec[3:0] == 4'h0);
    assign sec_half = (now_sec == 8'h00) || (now_sec == 8'h30);
    assign min_d0   = (now_min[3:0] == 4'h0);
    assign min_half = (now_min == 8'h00) || (now_min == 8'h30);

    always_comb begin
        hit = 1'b0;
        if ((rate_code != '0) && (rate_code <= C_SUB_MAX)) hit = sub_hit[rate_code];
        else if (rate_code == C_1S)  hit = tick_sec;
        else if (rate_code == C_10S) hit = tick_sec & sec_d0;
        else if (rate_code == C_30S) hit = tick_sec & sec_half;
        else if (rate_code == C_1M)  hit = tick_min;
        else if (rate_code == C_10M) hit = tick_min & min_d0;
        else if (rate_code == C_30M) hit = tick_min & min_half;
        else if (rate_code == C_1H)  hit = tick_hr;
        else if (rate_code == C_1D)  hit = tick_day;
    end
endmodule

// File: rtl/irq_pf_sync.sv
module irq_pf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q[0] <= async_in;
            last_q     <= chain_q[STAGES-1];
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import irq_pkg::*;
#(
    parameter int SUB_RATES   = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_base,
    input  logic              tick_sec,
    input  logic              tick_min,
    input  logic              tick_hr,
    input  logic              tick_day,
    input  logic [BCD_W-1:0]  now_sec,
    input  logic [BCD_W-1:0]  now_min,
    input  logic [BCD_W-1:0]  now_hr,
    input  logic [BCD_W-1:0]  alm_sec,
    input  logic [BCD_W-1:0]  alm_min,
    input  logic [BCD_W-1:0]  alm_hr,
    input  logic              alarm_en,
    input  logic              pfail_en,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pfail_raw,
    input  logic              stat_rd,
    output logic [NUM_SRC-1:0] status,
    output logic              irq_oe,
    output logic              irq_n
);
    logic [BCD_W-1:0]   now_f [3];
    logic [BCD_W-1:0]   alm_f [3];
    logic               alm_hit, per_hit, pf_rise;
    logic [NUM_SRC-1:0] set_evt;
    logic [NUM_SRC-1:0] status_q;
    irq_state_e         state_q, state_d;

    assign now_f[0] = now_sec;
    assign now_f[1] = now_min;
    assign now_f[2] = now_hr;
    assign alm_f[0] = alm_sec;
    assign alm_f[1] = alm_min;
    assign alm_f[2] = alm_hr;

    irq_alarm_cmp #(.FIELDS(3)) u_alarm (
        .tick_sec (tick_sec),
        .enable   (alarm_en),
        .now_f    (now_f),
        .alm_f    (alm_f),
        .hit      (alm_hit)
    );

    irq_rate_sel #(.SUB_RATES(SUB_RATES)) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_base (tick_base),
        .tick_sec  (tick_sec),
        .tick_min  (tick_min),
        .tick_hr   (tick_hr),
        .tick_day  (tick_day),
        .now_sec   (now_sec),
        .now_min   (now_min),
        .rate_code (rate_code),
        .hit       (per_hit)
    );

    irq_pf_sync #(.STAGES(SYNC_STAGES)) u_pfs (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pfail_raw),
        .rise     (pf_rise)
    );

    always_comb begin
        set_evt          = '0;
        set_evt[SRC_ALM] = alm_hit;
        set_evt[SRC_PER] = per_hit;
        set_evt[SRC_PF]  = pf_rise & pfail_en;
    end

    // status flags: a read clears, a same-cycle set survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       status_q <= '0;
        else if (stat_rd) status_q <= set_evt;
        else              status_q <= status_q | set_evt;
    end

    // line state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (|set_evt)                state_d = IRQ_ASSERT;
            IRQ_ASSERT: if (stat_rd && !(|set_evt))  state_d = IRQ_IDLE;
            default:                                 state_d = IRQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_oe = (state_q == IRQ_ASSERT);
        irq_n  = ~irq_oe;
        status = status_q;
    end
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk
    import irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               stat_rd,
    input logic               tick_sec,
    input logic               alarm_en,
    input logic               pfail_en,
    input logic [CODE_W-1:0]  rate_code,
    input logic [NUM_SRC-1:0] set_evt,
    input logic [NUM_SRC-1:0] status,
    input logic               irq_oe,
    input logic               irq_n
);
    // R8: line follows the flags
    p_line_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe == (|status));

    p_pin_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !irq_oe);

    // R9: read clears all bits not set again in the read cycle
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> ((status & ~$past(set_evt)) == '0));

    // R2: alarm flag appears only after an enabled seconds tick
    p_alarm_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[SRC_ALM]) |-> $past(tick_sec && alarm_en));

    // R6: code 0 never raises the periodic flag
    p_rate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[SRC_PER]) |-> $past(rate_code != '0));

    // R7: power-fail flag requires its enable
    p_pf_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[SRC_PF]) |-> $past(pfail_en));
endmodule

bind rtc_irq_unit irq_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_rd   (stat_rd),
    .tick_sec  (tick_sec),
    .alarm_en  (alarm_en),
    .pfail_en  (pfail_en),
    .rate_code (rate_code),
    .set_evt   (set_evt),
    .status    (status),
    .irq_oe    (irq_oe),
    .irq_n     (irq_n)
);

// File: tb/rtc_irq_unit_bench.sv
module rtc_irq_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_base, tick_sec, tick_min, tick_hr, tick_day;
    logic [7:0] now_sec, now_min, now_hr, alm_sec, alm_min, alm_hr;
    logic       alarm_en, pfail_en, pfail_raw, stat_rd;
    logic [3:0] rate_code;
    logic [2:0] status;
    logic       irq_oe, irq_n;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    rtc_irq_unit u_rtc_irq_unit (
        .clk(clk), .rst_n(rst_n), .tick_base(tick_base), .tick_sec(tick_sec),
        .tick_min(tick_min), .tick_hr(tick_hr), .tick_day(tick_day),
        .now_sec(now_sec), .now_min(now_min), .now_hr(now_hr),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .alarm_en(alarm_en), .pfail_en(pfail_en), .rate_code(rate_code),
        .pfail_raw(pfail_raw), .stat_rd(stat_rd), .status(status),
        .irq_oe(irq_oe), .irq_n(irq_n)
    );

    // {code[24:21], sec,min,hr,day ticks[20:17], sec[16:9], min[8:1], expect[0]}
    localparam logic [24:0] VEC [16] = '{
        {4'd8,  4'b1000, 8'h05, 8'h00, 1'b1},
        {4'd8,  4'b0100, 8'h05, 8'h00, 1'b0},
        {4'd9,  4'b1000, 8'h10, 8'h00, 1'b1},
        {4'd9,  4'b1000, 8'h15, 8'h00, 1'b0},
        {4'd10, 4'b1000, 8'h30, 8'h00, 1'b1},
        {4'd10, 4'b1000, 8'h20, 8'h00, 1'b0},
        {4'd11, 4'b0100, 8'h00, 8'h07, 1'b1},
        {4'd11, 4'b1000, 8'h00, 8'h07, 1'b0},
        {4'd12, 4'b0100, 8'h00, 8'h40, 1'b1},
        {4'd12, 4'b0100, 8'h00, 8'h41, 1'b0},
        {4'd13, 4'b0100, 8'h00, 8'h30, 1'b1},
        {4'd13, 4'b0100, 8'h00, 8'h10, 1'b0},
        {4'd14, 4'b0010, 8'h00, 8'h00, 1'b1},
        {4'd14, 4'b0100, 8'h00, 8'h00, 1'b0},
        {4'd15, 4'b0001, 8'h00, 8'h00, 1'b1},
        {4'd15, 4'b0010, 8'h00, 8'h00, 1'b0}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_ticks();
        {tick_base, tick_sec, tick_min, tick_hr, tick_day} = '0;
    endtask

    task automatic read_status();
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; clear_ticks();
        {now_sec, now_min, now_hr} = '0;
        alm_sec = 8'h56; alm_min = 8'h34; alm_hr = 8'h12;
        alarm_en = 0; pfail_en = 0; pfail_raw = 0; stat_rd = 0; rate_code = 0;
        step(); step();
        check("R1 status in reset", status, 0);
        check("R1 irq_n in reset", irq_n, 1);
        rst_n = 1'b1;
        step();
        check("R1 status after reset", status, 0);
        check("R1 irq_oe after reset", irq_oe, 0);

        // table of slow periodic codes (R5), line behaviour (R8), read clear (R9)
        for (int i = 0; i < 16; i++) begin
            rate_code = VEC[i][24:21];
            {tick_sec, tick_min, tick_hr, tick_day} = VEC[i][20:17];
            now_sec = VEC[i][16:9];
            now_min = VEC[i][8:1];
            step();
            clear_ticks();
            check($sformatf("R5 code %0d row %0d", VEC[i][24:21], i), status[1], VEC[i][0]);
            check("R8 pin vs flags", irq_n, !VEC[i][0]);
            read_status();
            check("R9 cleared after read", status, 0);
        end

        // alarm (R2, R3)
        rate_code = 0; alarm_en = 1;
        now_sec = 8'h56; now_min = 8'h34; now_hr = 8'h12;
        tick_sec = 1; step(); clear_ticks();
        check("R2 alarm on match", status, 3'b001);
        check("R8 pin low on alarm", irq_n, 0);
        read_status();
        check("R9 alarm cleared", status, 0);
        check("R8 pin released", irq_n, 1);
        step(); step();
        check("R3 match without tick", status, 0);
        now_min = 8'h35; tick_sec = 1; step(); clear_ticks();
        check("R3 minute differs", status, 0);
        now_min = 8'h34; alarm_en = 0; tick_sec = 1; step(); clear_ticks();
        check("R3 alarm disabled", status, 0);

        // R9: read with a simultaneous new event
        alarm_en = 1; tick_sec = 1; step(); clear_ticks();
        check("R2 alarm again", status, 3'b001);
        now_sec = 8'h57; rate_code = 4'd8; tick_sec = 1; stat_rd = 1;
        step(); clear_ticks(); stat_rd = 0;
        check("R9 same-cycle set kept", status, 3'b010);
        check("R8 pin held low", irq_n, 0);
        alarm_en = 0; read_status();
        check("R9 clear", status, 0);

        // sub-second rates (R4): base-tick count n from reset
        rate_code = 4'd3;
        for (int n = 1; n <= 8; n++) begin
            tick_base = 1; step(); clear_ticks();
            check($sformatf("R4 code3 tick %0d", n), status[1], (n % 4) == 0);
            if (status[1]) read_status();
        end
        rate_code = 4'd1;
        tick_base = 1; step(); clear_ticks();
        check("R4 code1 tick 9", status[1], 1);
        read_status();
        rate_code = 4'd7;
        for (int n = 10; n <= 64; n++) begin
            tick_base = 1; step(); clear_ticks();
            check($sformatf("R4 code7 tick %0d", n), status[1], (n % 64) == 0);
            if (status[1]) read_status();
        end

        // R6: code 0 ignores every tick
        rate_code = 0;
        {tick_base, tick_sec, tick_min, tick_hr, tick_day} = '1;
        now_sec = 8'h00; now_min = 8'h00;
        step(); clear_ticks();
        check("R6 code 0 silent", status, 0);
        check("R6 pin released", irq_n, 1);

        // power fail (R7)
        pfail_en = 1; pfail_raw = 1;
        step(); step(); step();
        check("R7 pfail flag", status, 3'b100);
        read_status();
        step(); step();
        check("R7 once per edge", status, 0);
        pfail_raw = 0; pfail_en = 0; step(); step(); step();
        pfail_raw = 1; step(); step(); step(); step();
        check("R7 disabled", status, 0);
        check("R8 released at end", irq_oe, 0);

        done = 1'b1;
        summary();
    end
endmodule